// File: doc/BRIEF.md
# Pseudo-SRAM Page-Read Host Controller

This block sits between a synchronous on-chip requester and an external 16-bit asynchronous pseudo-SRAM that offers a fast in-page read mode. A command port with valid/ready handshaking accepts three kinds of request: a single-word write with per-byte lane enables, a single-word read, and a read burst of one to eight words. The controller turns each request into the active-low chip-select, write-strobe, output-enable and two byte-lane strobes that such a memory expects, drives the 21-bit word address and the write data, and returns read words on a registered result port.

Every analog minimum is a nanosecond parameter that is turned into a whole number of clock cycles by rounding up at the configured clock period. A read burst opens a page with one full random access. The following words in the same aligned 8-word page are fetched by changing only the three low address bits, each after the shorter in-page access time. When a burst reaches the end of its page while words remain, the controller raises chip-select for the minimum high time and reopens the next page with a new random access. A burst therefore never keeps a page open across an 8-word boundary, and chip-select never stays low for longer than the open-page limit.

Top module: `psram_page_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all five memory strobes are high (inactive), `mem_dq_oe` is 0, `rd_valid` is 0 and `cmd_ready` is 1.
- R2: A read is captured exactly T_RAND cycles after the clock edge that accepts it, where T_RAND = ceil(65 ns / clock period) (13 at 5 ns). The returned word equals the memory word at the requested address, and both byte strobes are low during a read.
- R3: While chip-select stays low, address bits 20..3 do not change. Each further in-page word is captured T_PAGE = ceil(20 ns / period) cycles (4) after the previous one, with bits 2..0 incremented by one.
- R4: A read command whose `cmd_len` field is n returns n+1 words from consecutive addresses (wrapping modulo 2^21). `rd_last` is 1 on the final word only.
- R5: When a burst steps from a word whose bits 2..0 are 7 to the next word, chip-select rises for T_CEHI = ceil(10 ns / period) cycles (2) and the page reopens with a full random access, so the two captures are T_CEHI + T_RAND cycles apart. Every chip-select high interval lasts at least T_CEHI cycles.
- R6: A write holds chip-select, write-strobe and the selected lane strobes low together for T_WP = ceil(40 ns / period) cycles (8). Data is driven and stable throughout, and the memory takes the data present when the pulse ends.
- R7: Output-enable is high in every cycle in which write-strobe is low.
- R8: `cmd_be` bit 0 enables the lower lane (strobe `mem_lb_n`, data bits 7..0) and bit 1 the upper lane (`mem_ub_n`, bits 15..8). A disabled lane's byte in memory is left unchanged. A write with `cmd_be` = 0 produces no strobe at all and is consumed with `cmd_ready` remaining 1. Whenever chip-select is low, at least one lane strobe is low.
- R9: Chip-select never stays low for T_OPEN = ceil(4000 ns / period) cycles (800) or more.
- R10: Two successive falling edges of chip-select are at least T_RAND cycles apart, so the read and write cycle minimums hold.
- R11: `cmd_ready` is 1 only when the controller is idle. It is 0 in the cycle after a read or a non-empty write is accepted, until that access and its recovery have ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command taken on valid and ready |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 21 | Word address of the first word |
| cmd_len | input | 3 | Read words minus one (ignored for writes) |
| cmd_wdata | input | 16 | Write data |
| cmd_be | input | 2 | Write lane enables, bit 0 low byte, bit 1 high byte |
| rd_valid | output | 1 | One-cycle pulse with a read word |
| rd_data | output | 16 | Read word |
| rd_last | output | 1 | Marks the last word of a read command |
| mem_addr | output | 21 | Memory word address |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Write data toward the pads |
| mem_dq_oe | output | 1 | Pad driver enable for write data |
| mem_dq_i | input | 16 | Read data from the pads |

## Verification
The embedded properties assume that the memory returns valid data once the access time measured in cycles has elapsed. They also assume that the requester changes command fields only while `cmd_valid` is presented to an idle controller. The bench keeps to both. Its behavioural memory returns a poison word whenever a read is sampled before T_RAND or T_PAGE cycles of stable address. The bench also issues each command only after observing `cmd_ready`, so any early capture shows up as a data miscompare. The memory model also measures pulse widths, chip-select gaps and open-page time at the pins. The stimulus sweeps every start offset within a page against every burst length, including bursts that wrap at the top of the address space, and every lane-enable value.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_GAP
  } ctl_st_t;

  // whole clock cycles covering a nanosecond minimum, rounded up
  function automatic int cyc_of(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/psram_dly_cnt.sv
module psram_dly_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/psram_page_step.sv
module psram_page_step #(
  parameter int AW         = 21,
  parameter int PAGE_WORDS = 8
) (
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] nxt,
  output logic          last_in_page
);

  localparam int PB = $clog2(PAGE_WORDS);

  assign nxt          = addr + 1'b1;
  assign last_in_page = &addr[PB-1:0];

endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl #(
  parameter int AW            = 21,
  parameter int DW            = 16,
  parameter int PAGE_WORDS    = 8,
  parameter int CLK_PS        = 5000,
  parameter int T_RAND_NS     = 65,
  parameter int T_PAGE_NS     = 20,
  parameter int T_CEHI_NS     = 10,
  parameter int T_WP_NS       = 40,
  parameter int T_OPEN_MAX_NS = 4000,
  localparam int LW           = $clog2(PAGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [DW-1:0] cmd_wdata,
  input  logic [1:0]    cmd_be,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  import psram_pkg::*;

  localparam int PB       = $clog2(PAGE_WORDS);
  localparam int T_RAND_C = cyc_of(T_RAND_NS, CLK_PS);
  localparam int T_PAGE_C = cyc_of(T_PAGE_NS, CLK_PS);
  localparam int T_CEHI_C = cyc_of(T_CEHI_NS, CLK_PS);
  localparam int T_WP_C   = cyc_of(T_WP_NS, CLK_PS);
  localparam int T_OPEN_C = cyc_of(T_OPEN_MAX_NS, CLK_PS);
  localparam int T_REC_C  = (T_RAND_C > T_WP_C + T_CEHI_C) ? (T_RAND_C - T_WP_C) : T_CEHI_C;
  localparam int CW       = $clog2(T_RAND_C + T_WP_C + T_CEHI_C + 1);
  localparam int HW       = $clog2(T_CEHI_C + 2);
  localparam int OW       = $clog2(T_OPEN_C + 2);

  localparam logic [CW-1:0] RAND_LD = CW'(T_RAND_C - 1);
  localparam logic [CW-1:0] PAGE_LD = CW'(T_PAGE_C - 1);
  localparam logic [CW-1:0] CEHI_LD = CW'(T_CEHI_C - 1);
  localparam logic [CW-1:0] WP_LD   = CW'(T_WP_C - 1);
  localparam logic [CW-1:0] REC_LD  = CW'(T_REC_C - 1);

  ctl_st_t       state;
  logic [LW-1:0] left_q;
  logic          more_q;
  logic          cnt_ld;
  logic [CW-1:0] cnt_val;
  logic          cnt_zero;
  logic [AW-1:0] addr_nxt;
  logic          page_end;

  psram_dly_cnt #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_ld),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  psram_page_step #(.AW(AW), .PAGE_WORDS(PAGE_WORDS)) u_step (
    .addr         (mem_addr),
    .nxt          (addr_nxt),
    .last_in_page (page_end)
  );

  assign cmd_ready = (state == ST_IDLE);

  // wait length chosen for the step that starts at this edge
  always_comb begin
    cnt_ld  = 1'b0;
    cnt_val = '0;
    case (state)
      ST_IDLE: if (cmd_valid) begin
        if (!cmd_write) begin
          cnt_ld  = 1'b1;
          cnt_val = RAND_LD;
        end else if (cmd_be != 2'b00) begin
          cnt_ld  = 1'b1;
          cnt_val = WP_LD;
        end
      end
      ST_RD: if (cnt_zero) begin
        cnt_ld  = 1'b1;
        cnt_val = (left_q != '0 && !page_end) ? PAGE_LD : CEHI_LD;
      end
      ST_WR: if (cnt_zero) begin
        cnt_ld  = 1'b1;
        cnt_val = REC_LD;
      end
      ST_GAP: if (cnt_zero && more_q) begin
        cnt_ld  = 1'b1;
        cnt_val = RAND_LD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      left_q    <= '0;
      more_q    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_last   <= 1'b0;
      rd_data   <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      case (state)
        ST_IDLE: if (cmd_valid) begin
          if (!cmd_write) begin
            mem_addr <= cmd_addr;
            left_q   <= cmd_len;
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            mem_lb_n <= 1'b0;
            mem_ub_n <= 1'b0;
            state    <= ST_RD;
          end else if (cmd_be != 2'b00) begin
            mem_addr  <= cmd_addr;
            mem_ce_n  <= 1'b0;
            mem_we_n  <= 1'b0;
            mem_lb_n  <= ~cmd_be[0];
            mem_ub_n  <= ~cmd_be[1];
            mem_dq_o  <= cmd_wdata;
            mem_dq_oe <= 1'b1;
            state     <= ST_WR;
          end
        end
        ST_RD: if (cnt_zero) begin
          rd_data  <= mem_dq_i;
          rd_valid <= 1'b1;
          if (left_q == '0) begin
            rd_last  <= 1'b1;
            more_q   <= 1'b0;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
            state    <= ST_GAP;
          end else begin
            left_q   <= left_q - 1'b1;
            mem_addr <= addr_nxt;
            if (page_end) begin
              more_q   <= 1'b1;
              mem_ce_n <= 1'b1;
              mem_oe_n <= 1'b1;
              mem_lb_n <= 1'b1;
              mem_ub_n <= 1'b1;
              state    <= ST_GAP;
            end
          end
        end
        ST_WR: if (cnt_zero) begin
          mem_ce_n  <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          more_q    <= 1'b0;
          state     <= ST_GAP;
        end
        ST_GAP: if (cnt_zero) begin
          if (more_q) begin
            more_q   <= 1'b0;
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            mem_lb_n <= 1'b0;
            mem_ub_n <= 1'b0;
            state    <= ST_RD;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // pin-level run lengths used only by the properties below
  logic [HW-1:0] hi_run;
  logic [OW-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= HW'(T_CEHI_C);
      lo_run <= '0;
    end else begin
      if (mem_ce_n) begin
        lo_run <= '0;
        if (hi_run < HW'(T_CEHI_C)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run < OW'(T_OPEN_C)) lo_run <= lo_run + 1'b1;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $fell(rst) |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && cmd_ready))
    else $error("reset state");

  p_page_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[AW-1:PB] == $past(mem_addr[AW-1:PB])))
    else $error("page address moved while open");

  p_ce_high_min_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (hi_run >= HW'(T_CEHI_C)))
    else $error("chip-select high too short");

  p_wr_data_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && mem_dq_oe && !mem_ce_n))
    else $error("write data moved in pulse");

  p_oe_off_in_wr_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n)
    else $error("output enable low during write");

  p_lane_sel_r8: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !(mem_lb_n && mem_ub_n))
    else $error("access with no lane");

  p_open_limit_r9: assert property (@(posedge clk) disable iff (rst)
    lo_run < OW'(T_OPEN_C))
    else $error("page open too long");

  p_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_valid || !mem_ce_n) |-> !cmd_ready)
    else $error("ready while busy");

endmodule

// File: tb/psram_page_ctrl_tb.sv
module psram_page_ctrl_tb;

  localparam int CLK_PS = 5000;
  localparam int T_RAND = (65 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_PAGE = (20 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_CEHI = (10 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_WP   = (40 * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int T_OPEN = (4000 * 1000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic        cmd_ready;
  logic [20:0] cmd_addr = '0;
  logic [2:0]  cmd_len = '0;
  logic [15:0] cmd_wdata = '0;
  logic [1:0]  cmd_be = '0;
  logic        rd_valid, rd_last;
  logic [15:0] rd_data;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  psram_page_ctrl u_dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory, 256 words aliased on bits 7..0
  logic [15:0] mdl_mem [256];
  logic [15:0] exp_mem [256];
  int          hi_age = 0, lo_age = 0, wp_cnt = 0, ce_hi = 1000, fall_age = 1000, lo_run = 0;
  logic        p_ce_n = 1'b1, p_pulse = 1'b0;
  logic [20:0] p_addr = '0;
  logic [15:0] p_dq = '0;
  logic        p_lb_n = 1'b1, p_ub_n = 1'b1;
  logic        pulse;

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl_mem[i] = 16'(i * 257) ^ 16'h5A3C;
      exp_mem[i] = 16'(i * 257) ^ 16'h5A3C;
    end
  end

  assign pulse = !mem_ce_n && !mem_we_n && (!mem_lb_n || !mem_ub_n);

  wire rd_ok = !mem_ce_n && !mem_oe_n && mem_we_n &&
               (hi_age >= T_RAND - 1) && (lo_age >= T_PAGE - 1);
  assign mem_dq_i = rd_ok ? {mem_ub_n ? 8'hEE : mdl_mem[mem_addr[7:0]][15:8],
                             mem_lb_n ? 8'hEE : mdl_mem[mem_addr[7:0]][7:0]}
                          : 16'hBAD0;

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_ce_n) begin
        hi_age <= 0;
        lo_age <= 0;
      end else begin
        hi_age <= (p_ce_n || mem_addr[20:3] != p_addr[20:3]) ? 1 : hi_age + 1;
        lo_age <= (p_ce_n || mem_addr[2:0] != p_addr[2:0]) ? 1 : lo_age + 1;
        if (!p_ce_n && mem_addr[20:3] != p_addr[20:3])
          chk(1'b0, "R3", "high address moved in open page", {11'd0, mem_addr}, {11'd0, p_addr});
      end
      if (!mem_ce_n && p_ce_n) begin
        chk(ce_hi >= T_CEHI, "R5", "chip-select high cycles", ce_hi, T_CEHI);
        chk(fall_age + 1 >= T_RAND, "R10", "cycles between chip-select falls", fall_age + 1, T_RAND);
        fall_age <= 0;
      end else begin
        fall_age <= fall_age + 1;
      end
      ce_hi <= mem_ce_n ? ce_hi + 1 : 0;
      lo_run <= mem_ce_n ? 0 : lo_run + 1;
      if (mem_ce_n && !p_ce_n)
        chk(lo_run < T_OPEN, "R9", "chip-select low cycles", lo_run, T_OPEN);
      if (!mem_we_n && !mem_oe_n)
        chk(1'b0, "R7", "output enable low with write strobe", 32'd0, 32'd1);
      if (pulse && p_pulse && mem_dq_o != p_dq)
        chk(1'b0, "R6", "write data moved in pulse", mem_dq_o, p_dq);
      if (p_pulse && !pulse) begin
        chk(wp_cnt >= T_WP, "R6", "write pulse cycles", wp_cnt, T_WP);
        if (!p_lb_n) mdl_mem[p_addr[7:0]][7:0]  <= p_dq[7:0];
        if (!p_ub_n) mdl_mem[p_addr[7:0]][15:8] <= p_dq[15:8];
      end
      wp_cnt  <= pulse ? wp_cnt + 1 : 0;
      p_ce_n  <= mem_ce_n;
      p_pulse <= pulse;
      p_addr  <= mem_addr;
      p_dq    <= mem_dq_o;
      p_lb_n  <= mem_lb_n;
      p_ub_n  <= mem_ub_n;
    end
  end

  // ---------------- stimulus
  task automatic wait_ready();
    do @(negedge clk); while (!cmd_ready);
  endtask

  task automatic issue(input bit wr, input logic [20:0] a, input logic [2:0] len,
                       input logic [15:0] d, input logic [1:0] be);
    wait_ready();
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_len = len;
    cmd_wdata = d; cmd_be = be;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wr && be == 2'b00)
      chk(cmd_ready == 1'b1, "R8", "ready after empty write", cmd_ready, 1);
    else
      chk(cmd_ready == 1'b0, "R11", "ready after accept", cmd_ready, 0);
  endtask

  task automatic burst(input logic [20:0] a, input int len);
    int gap;
    issue(1'b0, a, 3'(len), 16'h0, 2'b11);
    for (int i = 0; i <= len; i++) begin
      logic [20:0] wa;
      gap = 0;
      while (!rd_valid && gap < 100) begin
        @(negedge clk);
        gap++;
      end
      wa = a + 21'(i);
      if (i == 0)
        chk(gap == T_RAND, "R2", "first word latency", gap, T_RAND);
      else if (wa[2:0] == 3'd0)
        chk(gap + 1 == T_CEHI + T_RAND, "R5", "page crossing spacing", gap + 1, T_CEHI + T_RAND);
      else
        chk(gap + 1 == T_PAGE, "R3", "in-page spacing", gap + 1, T_PAGE);
      chk(rd_data == exp_mem[wa[7:0]], "R4", "burst word", rd_data, exp_mem[wa[7:0]]);
      chk(rd_last == (i == len), "R4", "last flag", rd_last, i == len);
      @(negedge clk);
    end
  endtask

  task automatic write(input logic [20:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, 3'd0, d, be);
    if (be[0]) exp_mem[a[7:0]][7:0]  = d[7:0];
    if (be[1]) exp_mem[a[7:0]][15:8] = d[15:8];
    if (be == 2'b00) begin
      repeat (T_WP + 2) begin
        chk(mem_ce_n && mem_we_n, "R8", "no strobe for empty write", {mem_ce_n, mem_we_n}, 2'b11);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R1", "strobes in reset",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1F);
    chk(!mem_dq_oe && !rd_valid && cmd_ready, "R1", "outputs in reset",
        {mem_dq_oe, rd_valid, cmd_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(mem_ce_n && !mem_dq_oe && cmd_ready, "R1", "first cycle after reset",
        {mem_ce_n, mem_dq_oe, cmd_ready}, 3'b101);

    // single random reads (R2)
    burst(21'h000000, 0);
    burst(21'h15A5A5, 0);
    burst(21'h1FFFFF, 0);

    // every start offset against every length (R3, R4, R5)
    for (int off = 0; off < 8; off++)
      for (int len = 0; len < 8; len++)
        burst(21'h000120 + 21'(off), len);

    // wrap at the top of the address space
    burst(21'h1FFFFC, 7);
    burst(21'h0ABCDE, 7);

    // lane enables (R6, R8), then read back
    for (int be = 0; be < 4; be++)
      write(21'h0000A0 + 21'(be), 16'hC3D0 + 16'(be * 16'h1111), 2'(be));
    burst(21'h0000A0, 3);

    // write then immediate read across a page (R7, R10)
    write(21'h0000F7, 16'h1234, 2'b11);
    write(21'h0000F8, 16'hFEDC, 2'b11);
    burst(21'h0000F6, 3);
    write(21'h0000F8, 16'h00AA, 2'b01);
    burst(21'h0000F8, 0);

    wait_ready();
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R11", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule